// File: doc/BRIEF.md
# Reset-or-Persist Fixed-Point Product Accumulator

This block multiplies two signed fixed-point operands on each accepted input beat. It scales the product back to the operand format and accumulates it into a single register. The data format is 32-bit two's complement with 24 integer bits and 8 fractional bits. Accumulation wraps modulo 2^32 and never saturates.

There are two accumulation policies. In reduce policy the register acts as if it were cleared at every iteration start: the first accepted element of an iteration replaces whatever the register held, and later elements add onto it. In fold policy the register persists across iterations: every element adds onto the current contents, including a value loaded through the initial-value port. A build parameter fixes the policy, or hands the choice to a mode input that is sampled every cycle.

An iteration is opened by a start strobe and closed by an element flagged as last. After the closing element a one-cycle done pulse appears. The result then holds until the next start, the explicit clear or an initial-value load.

Top module: `fxp_acc_top`

## Requirements
- R1: Each accepted element contributes floor(a*b / 256) of the signed 64-bit product of its two operands, taken modulo 2^32. This is the Q24.8 product with 8 fractional bits dropped, rounded toward minus infinity.
- R2: In reduce policy, the first accepted element after reset, after clear or after a start strobe is written directly into the register. An element accepted in the same cycle as a start strobe counts as the first of the new iteration.
- R3: In reduce policy, each later accepted element of the same iteration is added to the stored value.
- R4: In reduce policy, a value loaded through the initial-value port has no effect on an iteration's result, because the iteration's first element overwrites it.
- R5: In fold policy, a start strobe does not clear the register, and every accepted element is added to the current contents, including a loaded initial value.
- R6: A high `clr_i` sets the register to 0 on the next edge in either policy. It has priority over an initial-value load and over an input element, and both of those are dropped. A high `init_load_i` without clear loads `init_val_i` and drops an element offered in that cycle.
- R7: Addition wraps modulo 2^32 in two's complement, with no saturation.
- R8: `done_o` is high for exactly the one cycle after the cycle in which an element with `in_last_i` high was accepted. In that cycle `acc_o` already shows the sum including that element.
- R9: After a last element has been accepted, input elements are ignored and `acc_o` stays unchanged until a start strobe, a clear or an initial-value load. Reset and clear leave the block open, so it accepts elements.
- R10: Parameter `MODE_CFG` selects the policy: MODE_REDUCE (0) and MODE_FOLD (1) fix it. MODE_RUNTIME (2, the default) takes it from `mode_fold_i` each cycle, where 1 means fold and 0 means reduce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the register and opens the block |
| clr_i | input | 1 | Explicit clear of the accumulator |
| mode_fold_i | input | 1 | Policy when MODE_CFG is MODE_RUNTIME: 1 fold, 0 reduce |
| init_load_i | input | 1 | Load the initial value into the register |
| init_val_i | input | 32 | Initial value, Q24.8 |
| start_i | input | 1 | Start of a parent iteration |
| in_valid_i | input | 1 | Element present on the operand inputs |
| in_a_i | input | 32 | First operand, Q24.8 |
| in_b_i | input | 32 | Second operand, Q24.8 |
| in_last_i | input | 1 | Element is the last of the iteration |
| acc_o | output | 32 | Accumulator value, Q24.8 |
| done_o | output | 1 | One-cycle pulse after the last element is added |

## Verification
The product is combinational and the accumulator is one register, so every accepted element, clear or load appears on `acc_o` one clock edge after the cycle it was offered. `done_o` rises at that same edge. The bench changes inputs on the falling edge and lets one rising edge pass. It then samples `acc_o` and `done_o` on the following falling edge and compares them with a model updated on that rising edge. Closed-gate, priority and policy cases are all checked with this one-edge latency at the ports.

// File: rtl/fxp_acc_pkg.sv
package fxp_acc_pkg;

  typedef enum logic [1:0] {
    MODE_REDUCE  = 2'd0,
    MODE_FOLD    = 2'd1,
    MODE_RUNTIME = 2'd2
  } mode_cfg_e;

  // What the datapath does with the register on the coming edge
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_INIT  = 3'd2,
    ACT_FIRST = 3'd3,
    ACT_ADD   = 3'd4
  } acc_act_e;

endpackage

// File: rtl/fxp_acc_product.sv
module fxp_acc_product #(
  parameter int unsigned INT_BITS  = 24,
  parameter int unsigned FRAC_BITS = 8
) (
  input  logic [INT_BITS+FRAC_BITS-1:0] a_i,
  input  logic [INT_BITS+FRAC_BITS-1:0] b_i,
  output logic [INT_BITS+FRAC_BITS-1:0] prod_o
);

  localparam int unsigned W  = INT_BITS + FRAC_BITS;
  localparam int unsigned PW = 2 * W;

  // Signed full product, arithmetic shift drops the extra fraction bits
  // (floor), then the low W bits are kept (modulo 2^W).
  function automatic logic [W-1:0] scale_mul(input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    logic signed [PW-1:0] full;
    logic signed [PW-1:0] shifted;
    full    = PW'($signed(a)) * PW'($signed(b));
    shifted = full >>> FRAC_BITS;
    return shifted[W-1:0];
  endfunction

  assign prod_o = scale_mul(a_i, b_i);

endmodule

// File: rtl/fxp_acc_ctrl.sv
module fxp_acc_ctrl
  import fxp_acc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     init_load_i,
  input  logic     start_i,
  input  logic     valid_i,
  input  logic     last_i,
  input  logic     fold_i,
  output acc_act_e act_o,
  output logic     accept_o,
  output logic     open_o,
  output logic     done_o
);

  logic open_q, first_q, done_q;
  logic gate_w, first_now_w, accept_w;

  always_comb begin
    gate_w      = open_q | start_i;
    accept_w    = valid_i & ~clr_i & ~init_load_i & gate_w;
    first_now_w = ~fold_i & (start_i | first_q);
    if (clr_i)             act_o = ACT_CLEAR;
    else if (init_load_i)  act_o = ACT_INIT;
    else if (accept_w)     act_o = first_now_w ? ACT_FIRST : ACT_ADD;
    else                   act_o = ACT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b1;
      first_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= accept_w & last_i;
      if (clr_i) begin
        open_q  <= 1'b1;
        first_q <= 1'b1;
      end else begin
        if (start_i) begin
          open_q  <= 1'b1;
          first_q <= 1'b1;
        end
        if (accept_w) begin
          first_q <= 1'b0;
          if (last_i) open_q <= 1'b0;
        end
      end
    end
  end

  assign accept_o = accept_w;
  assign open_o   = open_q;
  assign done_o   = done_q;

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i && !clr_i && !init_load_i && (open_o || start_i)) |=> done_o) // R8
    else $error("done missing after last element");

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !valid_i) |=> !done_o) // R8
    else $error("done held longer than one cycle");

  AST_CLOSED_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && last_i && !start_i) |=> !open_o) // R9
    else $error("gate still open after last element");

endmodule

// File: rtl/fxp_acc_datapath.sv
module fxp_acc_datapath
  import fxp_acc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  acc_act_e     act_i,
  input  logic [W-1:0] init_val_i,
  input  logic [W-1:0] prod_i,
  output logic [W-1:0] acc_o
);

  logic [W-1:0] acc_q, acc_d;

  // Two's complement sum, carry out discarded
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] x,
                                            input logic [W-1:0] y);
    return x + y;
  endfunction

  always_comb begin
    unique case (act_i)
      ACT_CLEAR: acc_d = '0;
      ACT_INIT:  acc_d = init_val_i;
      ACT_FIRST: acc_d = prod_i;
      ACT_ADD:   acc_d = wrap_add(acc_q, prod_i);
      default:   acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_CLEAR) |=> (acc_o == '0)) // R6
    else $error("clear did not zero the register");

  AST_FIRST_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_FIRST) |=> (acc_o == $past(prod_i))) // R2
    else $error("first element did not overwrite");

  AST_ADD_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_ADD) |=> (acc_o == W'($past(acc_o) + $past(prod_i)))) // R7
    else $error("accumulate add wrong");

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_HOLD) |=> $stable(acc_o)) // R9
    else $error("register moved while idle");

endmodule

// File: rtl/fxp_acc_top.sv
module fxp_acc_top
  import fxp_acc_pkg::*;
#(
  parameter int unsigned INT_BITS  = 24,
  parameter int unsigned FRAC_BITS = 8,
  parameter mode_cfg_e   MODE_CFG  = MODE_RUNTIME
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          mode_fold_i,
  input  logic                          init_load_i,
  input  logic [INT_BITS+FRAC_BITS-1:0] init_val_i,
  input  logic                          start_i,
  input  logic                          in_valid_i,
  input  logic [INT_BITS+FRAC_BITS-1:0] in_a_i,
  input  logic [INT_BITS+FRAC_BITS-1:0] in_b_i,
  input  logic                          in_last_i,
  output logic [INT_BITS+FRAC_BITS-1:0] acc_o,
  output logic                          done_o
);

  localparam int unsigned W = INT_BITS + FRAC_BITS;

  logic         fold_w;
  logic [W-1:0] prod_w;
  acc_act_e     act_w;
  logic         accept_w;
  logic         open_w;

  generate
    if (MODE_CFG == MODE_REDUCE) begin : g_mode_reduce
      assign fold_w = 1'b0;
    end else if (MODE_CFG == MODE_FOLD) begin : g_mode_fold
      assign fold_w = 1'b1;
    end else begin : g_mode_runtime
      assign fold_w = mode_fold_i;
    end
  endgenerate

  fxp_acc_product #(
    .INT_BITS (INT_BITS),
    .FRAC_BITS(FRAC_BITS)
  ) u_product (
    .a_i   (in_a_i),
    .b_i   (in_b_i),
    .prod_o(prod_w)
  );

  fxp_acc_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .init_load_i(init_load_i),
    .start_i    (start_i),
    .valid_i    (in_valid_i),
    .last_i     (in_last_i),
    .fold_i     (fold_w),
    .act_o      (act_w),
    .accept_o   (accept_w),
    .open_o     (open_w),
    .done_o     (done_o)
  );

  fxp_acc_datapath #(
    .W(W)
  ) u_datapath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act_w),
    .init_val_i(init_val_i),
    .prod_i    (prod_w),
    .acc_o     (acc_o)
  );

  AST_CLOSED_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_w && !start_i && !clr_i && !init_load_i) |=> $stable(acc_o)) // R9
    else $error("element taken while closed");

  AST_FOLD_START_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fold_w && start_i && !in_valid_i && !clr_i && !init_load_i) |=> $stable(acc_o)) // R5
    else $error("fold start disturbed register");

  AST_INIT_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_load_i && !clr_i) |=> (acc_o == $past(init_val_i))) // R6
    else $error("initial value not loaded");

  AST_ACCEPT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_w |-> (in_valid_i && (open_w || start_i))) // R9
    else $error("accept without open gate");

endmodule

// File: tb/fxp_acc_top_tb.sv
module fxp_acc_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 0, fold = 0, init_ld = 0, start = 0, valid = 0, last = 0;
  logic [31:0] init_val = 0, a = 0, b = 0;
  logic [31:0] acc;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // model state
  logic [31:0] m_acc = 0;
  logic        m_open = 1, m_first = 1, m_done = 0;

  always #10 clk = ~clk; // 50 MHz

  fxp_acc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .mode_fold_i(fold),
    .init_load_i(init_ld), .init_val_i(init_val), .start_i(start),
    .in_valid_i(valid), .in_a_i(a), .in_b_i(b), .in_last_i(last),
    .acc_o(acc), .done_o(done)
  );

  // R1: floor division of the exact product by 256, low 32 bits kept
  function automatic logic [31:0] q_mul(input logic [31:0] x, input logic [31:0] y);
    longint p, q;
    p = longint'($signed(x)) * longint'($signed(y));
    q = p / 256;
    if (p < 0 && (p % 256) != 0) q = q - 1;
    return q[31:0];
  endfunction

  task automatic idle();
    clr = 0; init_ld = 0; start = 0; valid = 0; last = 0;
  endtask

  task automatic check(input string tag);
    checks++;
    if (acc !== m_acc || done !== m_done) begin
      errors++;
      $display("FAIL %s acc=%h exp=%h done=%b exp=%b", tag, acc, m_acc, done, m_done);
    end
  endtask

  // one edge: model follows requirements, then sample at the falling edge
  task automatic tick(input string tag);
    logic ok, first_now;
    @(posedge clk);
    ok        = valid && !clr && !init_ld && (m_open || start);
    first_now = !fold && (start || m_first);
    m_done    = ok && last;
    if (clr)           m_acc = 0;                           // R6
    else if (init_ld)  m_acc = init_val;
    else if (ok)       m_acc = first_now ? q_mul(a, b)      // R2
                                         : m_acc + q_mul(a, b); // R3 R5 R7
    if (clr) begin m_open = 1; m_first = 1; end
    else begin
      if (start) begin m_open = 1; m_first = 1; end
      if (ok) begin m_first = 0; if (last) m_open = 0; end   // R9
    end
    @(negedge clk);
    check(tag);
    idle();
  endtask

  task automatic elem(input logic [31:0] x, input logic [31:0] y,
                      input logic st, input logic ls, input string tag);
    valid = 1; a = x; b = y; start = st; last = ls;
    tick(tag);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL R8 watchdog cycles=%0d expected<=150000", cyc);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    idle();
    repeat (3) @(negedge clk);
    check("R9 reset state");
    rst_n = 1;
    @(negedge clk);

    // R1 R2: reduce, first element overwrites, sign floor
    fold = 0;
    elem(32'h0000_0300, 32'h0000_0280, 1, 0, "R2 first overwrite"); // 3*2.5
    elem(32'hFFFF_FF01, 32'h0000_0001, 0, 0, "R1 negative floor");
    elem(32'h0000_0100, 32'h0000_0100, 0, 1, "R3 add last");
    check("R8 done pulse");
    tick("R8 done one cycle");
    // R9: ignored after last
    elem(32'h0000_1000, 32'h0000_1000, 0, 0, "R9 ignored element");
    elem(32'h0000_0100, 32'h0000_0100, 0, 1, "R9 ignored last");

    // R4: reduce, init 5.0 has no effect
    init_ld = 1; init_val = 32'h0000_0500; tick("R6 init load");
    elem(32'h0000_0200, 32'h0000_0100, 1, 0, "R4 init overwritten");
    elem(32'h0000_0100, 32'h0000_0100, 0, 1, "R4 sum without init");

    // R5: fold, start keeps register and init counts
    fold = 1;
    init_ld = 1; init_val = 32'h0000_0500; tick("R5 init load");
    start = 1; tick("R5 start keeps");
    elem(32'h0000_0200, 32'h0000_0100, 0, 0, "R5 add on init");
    elem(32'h0000_0100, 32'h0000_0100, 0, 1, "R5 add last");
    elem(32'h0000_0100, 32'h0000_0100, 1, 1, "R5 start+valid adds");

    // R7: wrap past 2^31
    elem(32'h4000_0000, 32'h0000_0200, 1, 0, "R7 wrap");
    elem(32'h4000_0000, 32'h0000_0200, 0, 1, "R7 wrap twice");

    // R6: clear priority over init and element
    clr = 1; init_ld = 1; init_val = 32'h1234_5678; valid = 1; a = 32'h100; b = 32'h100;
    tick("R6 clear priority");
    init_ld = 1; init_val = 32'h0000_0700; valid = 1; a = 32'h100; b = 32'h100;
    tick("R6 init drops element");
    fold = 0;
    clr = 1; tick("R6 clear reduce");
    elem(32'h0000_0300, 32'h0000_0300, 0, 0, "R2 first after clear");
    // R10: runtime mode switch, fold adds onto reduce result
    fold = 1;
    elem(32'h0000_0100, 32'h0000_0200, 1, 1, "R10 runtime fold");

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int n;
      fold = $urandom_range(0, 1);
      n    = $urandom_range(1, 6);
      if ($urandom_range(0, 3) == 0) begin
        init_ld = 1; init_val = $urandom_range(0, 32'h0000_FFFF) - 32'h8000;
        tick("R4 R5 random init");
      end
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 4) == 0) tick("R9 random gap");
        if ($urandom_range(0, 19) == 0) begin clr = 1; tick("R6 random clear"); end
        elem($urandom_range(0, 4095) - 2048, $urandom_range(0, 4095) - 2048,
             (k == 0), (k == n - 1), fold ? "R5 random" : "R3 random");
      end
      if ($urandom_range(0, 3) == 0)
        elem($urandom, $urandom, 0, $urandom_range(0, 1), "R9 random after last");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule